// File: doc/BRIEF.md
# Compare Timer with Prioritised Interrupt Vector

This block is a free-running up-counter with a set of compare channels. Its interrupt sources reach software over two lines. The counter advances on every cycle in which the clock-enable input is high and the run bit is set. It climbs from zero to the value held in compare slot 0, then returns to zero. Each compare slot raises its own flag in the cycle its value equals the count. A wrap of the counter raises an overflow flag.

Slot 0 has an interrupt line of its own, and an acknowledge pulse clears its flag. The other slots and the overflow flag share a second line. Software serves that line through a vector register. Reading the vector register returns a code for the highest-priority source that is both flagged and enabled, and clears that one flag. Any other pending flags stay set and hold the shared line high. A flag is never cleared just because its interrupt is taken. Software can inspect a flag freely and can clear it by writing the slot's control word.

The register port is a simple synchronous strobe interface. Read data is combinational from the address. Any side effect of a read takes place at the clock edge in which the read strobe is high.

Top module: `tmr_cmp_top`

## Requirements
- R1: After reset the count is 0, all flags, enables and the run bit are 0, the vector reads 0, and both interrupt lines are low.
- R2: When `tick` and run (control bit 0) are both 1 at a clock edge, the count goes from the compare-0 value to 0, and otherwise increments by 1. In any other cycle the count holds.
- R3: Writing control (address 0) with bit 1 set forces the count to 0. That bit always reads back as 0.
- R4: A slot's flag (bit 1 of its control word at address 8+k) sets at the edge where the counter advances while the count equals that slot's compare value (address 4+k).
- R5: `irq_ch0` is high exactly when slot 0's flag and enable (bit 0 of its control word) are both 1. `irq_shared` is high when any slot k>=1 or the overflow source has both its flag and enable set. The overflow enable is control bit 2 and the overflow flag is control bit 3.
- R6: The vector (address 2) reads 0 when no shared source is pending. Otherwise it reads 2*k for the lowest-numbered pending slot k>=1, and 2*NCH (8 by default) when only the overflow source is pending.
- R7: A vector read clears only the flag of the source it reported. Other pending flags remain and keep `irq_shared` high.
- R8: Reading a slot control word has no side effect. Writing it loads the enable from bit 0 and the flag from bit 1, so writing flag 0 clears the flag.
- R9: A one-cycle pulse on `ack0` clears slot 0's flag.
- R10: If a match hits a flag in the same cycle as a clearing write or a vector read, the flag ends up set.
- R11: The overflow flag sets at the edge where the count wraps from the compare-0 value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, standing in for the selected timer clock |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for `bus_addr` |
| ack0 | input | 1 | Acknowledge pulse for the slot 0 interrupt |
| irq_ch0 | output | 1 | Dedicated interrupt of compare slot 0 |
| irq_shared | output | 1 | Shared interrupt of slots 1 and up and overflow |

## Verification
The counter is driven through a table of top values and step counts. The rows land before the top, exactly on it, one and two steps past it, several full periods on, with a top of 0, and with a top of all ones. Together they separate an off-by-one wrap from a missing wrap and from plain width overflow. The vector is tried with three slots pending together, and then with all slots and overflow pending. A draining sequence of 2, 4, 6, 8, 0 tells correct priority apart from wrong order and from clearing several flags at once. Flags set with the enable off, and collisions between a match and a write or a vector read, separate the gating and set-wins rules from a plain OR of flags.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTL = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT = 4'd1;
  localparam logic [ADDR_W-1:0] A_VEC = 4'd2;
  localparam int unsigned A_CCR_BASE  = 4;
  localparam int unsigned A_CCTL_BASE = 8;

  // control word bits
  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_CLR  = 1;
  localparam int unsigned B_OVIE = 2;
  localparam int unsigned B_OVFL = 3;

  // slot control word bits
  localparam int unsigned B_IE   = 0;
  localparam int unsigned B_FLAG = 1;

  typedef logic [7:0] vcode_t;

  // code reported for shared source slot (slot 0 = compare 1, last = overflow)
  function automatic vcode_t src_code(input int unsigned slot);
    return vcode_t'(2 * (slot + 1));
  endfunction

  // flag update: a match beats any write or clear in the same cycle
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic wr, input logic wval,
                                     input logic clr);
    if (set) return 1'b1;
    if (wr)  return wval;
    if (clr) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/tmr_cmp_counter.sv
module tmr_cmp_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clr,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  function automatic logic [W-1:0] advance(input logic [W-1:0] c,
                                           input logic [W-1:0] t);
    return (c == t) ? '0 : c + W'(1);
  endfunction

  assign wrap = step && (cnt == top);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= advance(cnt, top);
  end
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan import tmr_cmp_pkg::*; #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] cnt,
  input  logic         wr_ccr,
  input  logic [W-1:0] wdata,
  input  logic         wr_ctl,
  input  logic         ctl_ie,
  input  logic         ctl_flag,
  input  logic         ext_clr,
  output logic [W-1:0] ccr,
  output logic         ie,
  output logic         flag,
  output logic         hit
);
  assign hit = step && (cnt == ccr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccr  <= '0;
      ie   <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (wr_ccr) ccr <= wdata;
      if (wr_ctl) ie  <= ctl_ie;
      flag <= flag_next(flag, hit, wr_ctl, ctl_flag, ext_clr);
    end
  end
endmodule

// File: rtl/tmr_cmp_vec.sv
module tmr_cmp_vec import tmr_cmp_pkg::*; #(
  parameter int unsigned NSRC = 4
) (
  input  logic [NSRC-1:0] pend,
  output vcode_t          code,
  output logic [NSRC-1:0] pick
);
  // lowest index wins: scan from the top so the last hit is the winner
  always_comb begin
    code = '0;
    pick = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        code    = src_code(unsigned'(i));
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_cmp_top.sv
module tmr_cmp_top import tmr_cmp_pkg::*; #(
  parameter int unsigned W   = 16,
  parameter int unsigned NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              ack0,
  output logic              irq_ch0,
  output logic              irq_shared
);
  localparam int unsigned NSRC = NCH;  // slots 1..NCH-1 plus overflow

  logic                    run_q, ovie_q, ovfl_q;
  logic                    ctl_wr, clr_pulse, step, vec_rd, wrap, ovf_clr;
  logic [W-1:0]            cnt_q;
  logic [NCH-1:0][W-1:0]   ccr_q;
  logic [NCH-1:0]          ie_q, flag_q, hit, chan_wr, ccr_wr, ch_clr;
  logic [NSRC-1:0]         pend, pick;
  vcode_t                  vec_code;

  // named bus events
  assign ctl_wr    = bus_wr && (bus_addr == A_CTL);
  assign clr_pulse = ctl_wr && bus_wdata[B_CLR];
  assign vec_rd    = bus_rd && (bus_addr == A_VEC);
  assign step      = tick && run_q;

  tmr_cmp_counter #(.W(W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .step (step),
    .clr  (clr_pulse),
    .top  (ccr_q[0]),
    .cnt  (cnt_q),
    .wrap (wrap)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CCR  = ADDR_W'(A_CCR_BASE + k);
    localparam logic [ADDR_W-1:0] A_CCTL = ADDR_W'(A_CCTL_BASE + k);

    assign ccr_wr[k]  = bus_wr && (bus_addr == A_CCR);
    assign chan_wr[k] = bus_wr && (bus_addr == A_CCTL);

    if (k == 0) begin : g_ded
      assign ch_clr[k] = ack0;
    end else begin : g_shr
      assign ch_clr[k]  = vec_rd && pick[k-1];
      assign pend[k-1]  = flag_q[k] && ie_q[k];
    end

    tmr_cmp_chan #(.W(W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .cnt     (cnt_q),
      .wr_ccr  (ccr_wr[k]),
      .wdata   (bus_wdata),
      .wr_ctl  (chan_wr[k]),
      .ctl_ie  (bus_wdata[B_IE]),
      .ctl_flag(bus_wdata[B_FLAG]),
      .ext_clr (ch_clr[k]),
      .ccr     (ccr_q[k]),
      .ie      (ie_q[k]),
      .flag    (flag_q[k]),
      .hit     (hit[k])
    );
  end

  assign pend[NSRC-1] = ovfl_q && ovie_q;
  assign ovf_clr      = vec_rd && pick[NSRC-1];

  tmr_cmp_vec #(.NSRC(NSRC)) u_vec (
    .pend(pend),
    .code(vec_code),
    .pick(pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ovie_q <= 1'b0;
      ovfl_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        run_q  <= bus_wdata[B_RUN];
        ovie_q <= bus_wdata[B_OVIE];
      end
      ovfl_q <= flag_next(ovfl_q, wrap, ctl_wr, bus_wdata[B_OVFL], ovf_clr);
    end
  end

  assign irq_ch0    = flag_q[0] && ie_q[0];
  assign irq_shared = |pend;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTL) bus_rdata = W'({ovfl_q, ovie_q, 1'b0, run_q});
    if (bus_addr == A_CNT) bus_rdata = cnt_q;
    if (bus_addr == A_VEC) bus_rdata = W'(vec_code);
    for (int k = 0; k < NCH; k++) begin
      if (bus_addr == ADDR_W'(A_CCR_BASE + k))  bus_rdata = ccr_q[k];
      if (bus_addr == ADDR_W'(A_CCTL_BASE + k)) bus_rdata = W'({flag_q[k], ie_q[k]});
    end
  end
endmodule

// File: rtl/tmr_cmp_chk.sv
module tmr_cmp_chk #(
  parameter int unsigned W   = 16,
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           step,
  input logic           clr_pulse,
  input logic [W-1:0]   cnt,
  input logic [W-1:0]   top,
  input logic [NCH-1:0] hit,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] chan_wr,
  input logic           ack0,
  input logic           vec_rd,
  input logic [7:0]     vec_code,
  input logic           irq_shared
);
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step && (cnt == top) |=> cnt == '0);

  p_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clr_pulse && (cnt != top) |=> cnt == W'($past(cnt) + 1'b1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !clr_pulse |=> $stable(cnt));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> cnt == '0);

  for (genvar k = 0; k < NCH; k++) begin : g_hit
    // R4 and R10: a match leaves the flag set whatever else happens
    p_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit[k] |=> flag[k]);
  end

  p_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_code != 8'd0) == irq_shared);

  p_vec_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd && (vec_code == 8'd2) && !hit[1] && !chan_wr[1] |=> !flag[1]);

  p_vec_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd && (vec_code == 8'd2) && flag[NCH-1] && !chan_wr[NCH-1] |=> flag[NCH-1]);

  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack0 && !hit[0] && !chan_wr[0] |=> !flag[0]);
endmodule

bind tmr_cmp_top tmr_cmp_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step      (step),
  .clr_pulse (clr_pulse),
  .cnt       (cnt_q),
  .top       (ccr_q[0]),
  .hit       (hit),
  .flag      (flag_q),
  .chan_wr   (chan_wr),
  .ack0      (ack0),
  .vec_rd    (vec_rd),
  .vec_code  (vec_code),
  .irq_shared(irq_shared)
);

// File: tb/tb_tmr_cmp_top.sv
`timescale 1ns/1ps
module tb_tmr_cmp_top;
  localparam int W = 16;
  localparam logic [3:0] CTL = 4'd0, CNT = 4'd1, VEC = 4'd2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, ack0 = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic irq_ch0, irq_shared;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_cmp_top #(.W(W), .NCH(4)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack0(ack0), .irq_ch0(irq_ch0), .irq_shared(irq_shared)
  );

  // {top, steps after clear, expected count}
  localparam logic [47:0] TBL [7] = '{
    {16'd10,    16'd5,  16'd5},
    {16'd10,    16'd10, 16'd10},
    {16'd10,    16'd11, 16'd0},
    {16'd10,    16'd12, 16'd1},
    {16'd3,     16'd9,  16'd1},
    {16'd0,     16'd5,  16'd0},
    {16'd65535, 16'd20, 16'd20}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic step(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(CTL, v); chk("R1", "control", v, 0);
    rd(CNT, v); chk("R1", "count", v, 0);
    rd(VEC, v); chk("R1", "vector", v, 0);
    chk("R1", "irq_ch0", irq_ch0, 0);
    chk("R1", "irq_shared", irq_shared, 0);

    // R2 counting table
    for (int i = 0; i < 7; i++) begin
      wr(CTL, 16'd0);
      wr(4'd4, TBL[i][47:32]);
      wr(CTL, 16'd3);
      step(int'(TBL[i][31:16]));
      rd(CNT, v); chk("R2", $sformatf("table row %0d count", i), v, TBL[i][15:0]);
    end

    // R2 hold while stopped
    wr(CTL, 16'd0);
    step(5);
    rd(CNT, v); chk("R2", "hold when run off", v, 20);

    // R3 clear bit
    wr(CTL, 16'd3);
    rd(CTL, v); chk("R3", "clear reads zero", v, 1);
    rd(CNT, v); chk("R3", "count cleared", v, 0);

    // set up slots: top 20, slots at 5,7,9, all enabled, overflow enabled
    wr(CTL, 16'd0);
    wr(4'd4, 16'd20); wr(4'd5, 16'd5); wr(4'd6, 16'd7); wr(4'd7, 16'd9);
    for (int k = 0; k < 4; k++) wr(4'(8 + k), 16'd1);
    wr(CTL, 16'd7);

    // R4 flag on match
    step(6);
    rd(4'd9, v);  chk("R4", "slot1 flag after count 5", v, 3);
    rd(4'd10, v); chk("R4", "slot2 not yet", v, 1);
    chk("R5", "irq_shared with slot1", irq_shared, 1);
    chk("R5", "irq_ch0 idle", irq_ch0, 0);
    step(4);

    // R8 inspection has no side effect
    rd(4'd11, v); chk("R8", "slot3 read 1", v, 3);
    rd(4'd11, v); chk("R8", "slot3 read 2", v, 3);

    // R6/R7 draining in priority order
    rd(VEC, v); chk("R6", "first vector", v, 2);
    chk("R7", "irq_shared stays", irq_shared, 1);
    rd(4'd9, v);  chk("R7", "slot1 cleared", v, 1);
    rd(4'd10, v); chk("R7", "slot2 kept", v, 3);
    rd(VEC, v); chk("R6", "second vector", v, 4);
    rd(VEC, v); chk("R6", "third vector", v, 6);
    chk("R7", "irq_shared drops", irq_shared, 0);
    rd(VEC, v); chk("R6", "empty vector", v, 0);

    // R11 overflow and slot 0: count 10 -> steps visit 10..20 then wrap
    step(11);
    rd(CNT, v); chk("R2", "wrapped count", v, 0);
    chk("R5", "irq_ch0 on slot0", irq_ch0, 1);
    rd(CTL, v); chk("R11", "overflow flag", v, 13);
    rd(VEC, v); chk("R6", "overflow code", v, 8);
    rd(CTL, v); chk("R7", "overflow cleared", v, 5);
    chk("R7", "irq_shared low", irq_shared, 0);

    // R9 acknowledge
    @(negedge clk); ack0 = 1'b1;
    @(negedge clk); ack0 = 1'b0;
    chk("R9", "irq_ch0 after ack", irq_ch0, 0);
    rd(4'd8, v); chk("R9", "slot0 flag cleared", v, 1);

    // R6 full priority with overflow lowest
    step(21);
    rd(VEC, v); chk("R6", "all pending 1", v, 2);
    rd(VEC, v); chk("R6", "all pending 2", v, 4);
    rd(VEC, v); chk("R6", "all pending 3", v, 6);
    rd(VEC, v); chk("R6", "all pending 4", v, 8);
    rd(VEC, v); chk("R6", "all pending 5", v, 0);
    chk("R9", "slot0 untouched by vector", irq_ch0, 1);
    @(negedge clk); ack0 = 1'b1;
    @(negedge clk); ack0 = 1'b0;

    // R5 gating: slot2 enable off, count 0 -> 8
    wr(4'd10, 16'd0);
    step(8);
    rd(4'd10, v); chk("R5", "slot2 flag without enable", v, 2);
    rd(VEC, v); chk("R5", "vector skips slot1 first", v, 2);
    chk("R5", "disabled flag no irq", irq_shared, 0);
    rd(VEC, v); chk("R5", "disabled not vectored", v, 0);

    // R8 direct clear
    wr(4'd10, 16'd1);
    rd(4'd10, v); chk("R8", "write clears flag", v, 1);

    // R10 match vs clearing write: count is 8
    wr(4'd5, 16'd8);
    @(negedge clk);
    tick = 1'b1; bus_wr = 1'b1; bus_addr = 4'd9; bus_wdata = 16'd1;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd(4'd9, v); chk("R10", "match beats write", v, 3);

    // R10 match vs vector read: count is 9
    wr(4'd5, 16'd9);
    @(negedge clk);
    tick = 1'b1; bus_rd = 1'b1; bus_addr = VEC;
    #1 chk("R10", "vector before collision", bus_rdata, 2);
    @(negedge clk);
    tick = 1'b0; bus_rd = 1'b0;
    rd(4'd9, v); chk("R10", "match beats vector read", v, 3);
    rd(VEC, v); chk("R10", "slot1 still vectored", v, 2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule